// File: doc/BRIEF.md
# Tagged Translation Lookup Buffer

This block is the lookup stage of a memory management unit. It holds sixteen fully associative translation entries. Each lookup presents a virtual address, the current address-space identifier, the requester's secure/nonsecure state and the access kind (read or write, privileged or user). Every stored entry is compared in parallel on three tags: the virtual page, taking the entry's page size into account; the security-state bit; and the identifier, unless the entry is global.

When exactly one entry hits, the domain mode and the access-permission field of that entry decide whether the access may go ahead. An allowed access returns the physical address and the entry's attribute bits. A refused access returns a permission abort. When no entry hits, the block asks for a table walk or reports a section translation fault. The choice depends on a walk-disable bit, picked by the address region of the request. A programmable split divides the address space into a lower and an upper region.

Entries are loaded through a write port. The slot is chosen by a round-robin pointer. An invalidate-all input clears every entry in one cycle and sends the pointer back to slot 0. Software must keep at most one entry matching any lookup.

Top module: `tlb_match_unit`

## Requirements
- R1: After reset no entry is valid, `respValid` is low, and the first lookup misses.
- R2: An entry's virtual page matches when VA[31:S] equals the stored page tag, where S is 12, 16, 20 or 24 for a size code of 0, 1, 2 or 3.
- R3: An entry matches only when its stored secure bit equals `lookupNs`. Two entries with the same page and opposite secure bits each answer only their own state.
- R4: An entry matches only when its identifier equals `lookupAsid` or its global flag is set.
- R5: A miss gives `walkReq` when walks are enabled for the region of the address, and `transFault` otherwise. The upper region is every address whose top `regionSplit` bits are not all zero (a split of 0 makes every address lower). `walkDisHigh` governs the upper region and `walkDisLow` the lower region.
- R6: The 2-bit mode for domain d is `domainCtl[2d+1:2d]`. Mode 0 or 2 aborts. Mode 3 allows every access. Mode 1 applies the access field: 0 refuses all, 1 allows privileged only, 2 allows privileged any and user read, 3 allows all. A refused hit raises `permAbort`.
- R7: An allowed hit returns `respPa` equal to the stored physical base above bit S combined with VA bits [S-1:0], plus the entry's attribute bits on `respAttr`.
- R8: Results appear on the clock edge after the one that samples `lookupValid` and last one cycle. `respValid` is then high with exactly one of `respHit`, `permAbort`, `walkReq` or `transFault`. All of them are low otherwise.
- R9: Writes fill slots in round-robin order from slot 0, so the seventeenth write after an invalidate replaces the first entry written.
- R10: `invalidateAll` clears every entry in one cycle. It wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load one entry into the round-robin slot |
| wrVpn | input | 20 | Virtual page tag, VA[31:12] |
| wrSize | input | 2 | Page size code (0 to 3: 4 KB, 64 KB, 1 MB, 16 MB) |
| wrNs | input | 1 | Secure-state tag of the entry |
| wrGlobal | input | 1 | Entry matches any identifier |
| wrAsid | input | 8 | Address-space identifier of the entry |
| wrPfn | input | 20 | Physical base, PA[31:12] |
| wrAp | input | 2 | Access-permission field |
| wrDomain | input | 4 | Domain number |
| wrAttr | input | 5 | Memory attribute bits |
| invalidateAll | input | 1 | Clear all entries |
| lookupValid | input | 1 | Lookup request |
| lookupVa | input | 32 | Virtual address |
| lookupAsid | input | 8 | Current identifier |
| lookupNs | input | 1 | Requester is nonsecure |
| lookupWrite | input | 1 | Access is a write |
| lookupPriv | input | 1 | Access is privileged |
| walkDisLow | input | 1 | Walks disabled for the lower region |
| walkDisHigh | input | 1 | Walks disabled for the upper region |
| regionSplit | input | 3 | Count of top VA bits that select the upper region |
| domainCtl | input | 32 | 2-bit mode for each of 16 domains |
| respValid | output | 1 | Result present |
| respHit | output | 1 | Allowed hit |
| respPa | output | 32 | Physical address (zero unless hit) |
| respAttr | output | 5 | Attribute bits (zero unless hit) |
| permAbort | output | 1 | Hit refused by permission check |
| walkReq | output | 1 | Miss, walk requested |
| transFault | output | 1 | Miss, section translation fault |

## Verification
Every lookup result registers on the first rising edge after the request is sampled. The bench therefore drives each request on a falling edge and reads the result on the next falling edge. It reads once more a cycle later to confirm the outputs have returned to idle.

A write or an invalidate takes effect at the rising edge that samples it. A lookup issued on the following falling edge sees the new contents. The sweeps over page size, region split and the permission table rely on this.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W        = 32;
  localparam int PAGE_SHIFT  = 12;
  localparam int VPN_W       = VA_W - PAGE_SHIFT;
  localparam int PFN_W       = 20;
  localparam int ASID_W      = 8;
  localparam int DOM_W       = 4;
  localparam int ATTR_W      = 5;
  localparam int TLB_ENTRIES = 16;
  localparam int IDX_W       = $clog2(TLB_ENTRIES);
  localparam int SPLIT_W     = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        size;
    logic              ns;
    logic              global;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic [1:0]        ap;
    logic [DOM_W-1:0]  domain;
    logic [ATTR_W-1:0] attr;
  } tlbEntry_t;

  typedef struct packed {
    logic             wrStrobe;
    logic [IDX_W-1:0] wrIdx;
    logic             clearAll;
  } ctlStrobe_t;

  // Low page-number bits left out of the compare for each size code.
  function automatic logic [VPN_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0:    sizeMask = VPN_W'(0);
      2'd1:    sizeMask = VPN_W'(20'h0000F);
      2'd2:    sizeMask = VPN_W'(20'h000FF);
      default: sizeMask = VPN_W'(20'h00FFF);
    endcase
  endfunction
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  tlbEntry_t              wrEntry,
  input  logic [VPN_W-1:0]       lookVpn,
  input  logic [ASID_W-1:0]      lookAsid,
  input  logic                   lookNs,
  output logic [TLB_ENTRIES-1:0] matchVec,
  output logic [PFN_W-1:0]       selPfn,
  output logic [1:0]             selAp,
  output logic [DOM_W-1:0]       selDomain,
  output logic [ATTR_W-1:0]      selAttr
);
  tlbEntry_t              entryQ [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] validQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      validQ <= '0;
    end else if (strobe.wrStrobe) begin
      validQ[strobe.wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrStrobe) begin
      entryQ[strobe.wrIdx] <= wrEntry;
    end
  end

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] ignoreBits;
    logic             pageEq, asidOk;
    assign ignoreBits  = sizeMask(entryQ[g].size);
    assign pageEq      = ((entryQ[g].vpn ^ lookVpn) & ~ignoreBits) == '0;
    assign asidOk      = entryQ[g].global || (entryQ[g].asid == lookAsid);
    assign matchVec[g] = validQ[g] && pageEq && asidOk && (entryQ[g].ns == lookNs);
  end

  // AND-OR select; software keeps at most one bit of matchVec set.
  always_comb begin
    selPfn    = '0;
    selAp     = '0;
    selDomain = '0;
    selAttr   = '0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (matchVec[i]) begin
        selPfn    |= (entryQ[i].pfn & ~sizeMask(entryQ[i].size))
                   | (lookVpn & sizeMask(entryQ[i].size));
        selAp     |= entryQ[i].ap;
        selDomain |= entryQ[i].domain;
        selAttr   |= entryQ[i].attr;
      end
    end
  end
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    invalidateAll,
  input  logic                    lookupValid,
  input  logic [VPN_W-1:0]        lookVpn,
  input  logic [PAGE_SHIFT-1:0]   lookOffset,
  input  logic                    lookupWrite,
  input  logic                    lookupPriv,
  input  logic                    walkDisLow,
  input  logic                    walkDisHigh,
  input  logic [SPLIT_W-1:0]      regionSplit,
  input  logic [2*(1<<DOM_W)-1:0] domainCtl,
  input  logic [TLB_ENTRIES-1:0]  matchVec,
  input  logic [PFN_W-1:0]        selPfn,
  input  logic [1:0]              selAp,
  input  logic [DOM_W-1:0]        selDomain,
  input  logic [ATTR_W-1:0]       selAttr,
  output ctlStrobe_t              strobe,
  output logic                    respValid,
  output logic                    respHit,
  output logic [VA_W-1:0]         respPa,
  output logic [ATTR_W-1:0]       respAttr,
  output logic                    permAbort,
  output logic                    walkReq,
  output logic                    transFault
);
  logic [IDX_W-1:0] rrPtr;
  logic             anyHit, permOk, upperRegion, walkOff;
  logic [1:0]       domMode;
  logic [VPN_W-1:0] regionMask;

  always_ff @(posedge clk) begin
    if (!rstN || invalidateAll) begin
      rrPtr <= '0;
    end else if (wrEn) begin
      rrPtr <= (rrPtr == IDX_W'(TLB_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  assign strobe.wrStrobe = wrEn;
  assign strobe.wrIdx    = rrPtr;
  assign strobe.clearAll = invalidateAll;

  assign anyHit  = |matchVec;
  assign domMode = domainCtl[{selDomain, 1'b0} +: 2];

  always_comb begin
    case (domMode)
      2'b11: permOk = 1'b1;
      2'b01: begin
        case (selAp)
          2'd0:    permOk = 1'b0;
          2'd1:    permOk = lookupPriv;
          2'd2:    permOk = lookupPriv || !lookupWrite;
          default: permOk = 1'b1;
        endcase
      end
      default: permOk = 1'b0;
    endcase
  end

  assign regionMask  = ~({VPN_W{1'b1}} >> regionSplit);
  assign upperRegion = |(lookVpn & regionMask);
  assign walkOff     = upperRegion ? walkDisHigh : walkDisLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      permAbort  <= 1'b0;
      walkReq    <= 1'b0;
      transFault <= 1'b0;
      respPa     <= '0;
      respAttr   <= '0;
    end else begin
      respValid  <= lookupValid;
      respHit    <= lookupValid && anyHit && permOk;
      permAbort  <= lookupValid && anyHit && !permOk;
      walkReq    <= lookupValid && !anyHit && !walkOff;
      transFault <= lookupValid && !anyHit && walkOff;
      respPa     <= (lookupValid && anyHit && permOk) ? {selPfn, lookOffset} : '0;
      respAttr   <= (lookupValid && anyHit && permOk) ? selAttr : '0;
    end
  end
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [VPN_W-1:0]        wrVpn,
  input  logic [1:0]              wrSize,
  input  logic                    wrNs,
  input  logic                    wrGlobal,
  input  logic [ASID_W-1:0]       wrAsid,
  input  logic [PFN_W-1:0]        wrPfn,
  input  logic [1:0]              wrAp,
  input  logic [DOM_W-1:0]        wrDomain,
  input  logic [ATTR_W-1:0]       wrAttr,
  input  logic                    invalidateAll,
  input  logic                    lookupValid,
  input  logic [VA_W-1:0]         lookupVa,
  input  logic [ASID_W-1:0]       lookupAsid,
  input  logic                    lookupNs,
  input  logic                    lookupWrite,
  input  logic                    lookupPriv,
  input  logic                    walkDisLow,
  input  logic                    walkDisHigh,
  input  logic [SPLIT_W-1:0]      regionSplit,
  input  logic [2*(1<<DOM_W)-1:0] domainCtl,
  output logic                    respValid,
  output logic                    respHit,
  output logic [VA_W-1:0]         respPa,
  output logic [ATTR_W-1:0]       respAttr,
  output logic                    permAbort,
  output logic                    walkReq,
  output logic                    transFault
);
  ctlStrobe_t             strobe;
  tlbEntry_t              wrEntry;
  logic [TLB_ENTRIES-1:0] matchVec;
  logic [PFN_W-1:0]       selPfn;
  logic [1:0]             selAp;
  logic [DOM_W-1:0]       selDomain;
  logic [ATTR_W-1:0]      selAttr;

  assign wrEntry = '{vpn: wrVpn, size: wrSize, ns: wrNs, global: wrGlobal,
                     asid: wrAsid, pfn: wrPfn, ap: wrAp, domain: wrDomain,
                     attr: wrAttr};

  tlb_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEntry(wrEntry),
    .lookVpn(lookupVa[VA_W-1:PAGE_SHIFT]), .lookAsid(lookupAsid), .lookNs(lookupNs),
    .matchVec(matchVec), .selPfn(selPfn), .selAp(selAp),
    .selDomain(selDomain), .selAttr(selAttr)
  );

  tlb_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .invalidateAll(invalidateAll),
    .lookupValid(lookupValid), .lookVpn(lookupVa[VA_W-1:PAGE_SHIFT]),
    .lookOffset(lookupVa[PAGE_SHIFT-1:0]), .lookupWrite(lookupWrite),
    .lookupPriv(lookupPriv), .walkDisLow(walkDisLow), .walkDisHigh(walkDisHigh),
    .regionSplit(regionSplit), .domainCtl(domainCtl), .matchVec(matchVec),
    .selPfn(selPfn), .selAp(selAp), .selDomain(selDomain), .selAttr(selAttr),
    .strobe(strobe), .respValid(respValid), .respHit(respHit), .respPa(respPa),
    .respAttr(respAttr), .permAbort(permAbort), .walkReq(walkReq),
    .transFault(transFault)
  );
endmodule

// File: rtl/tlb_match_checker.sv
module tlb_match_checker
  import tlb_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   lookupValid,
  input logic                   invalidateAll,
  input logic                   respValid,
  input logic                   respHit,
  input logic                   permAbort,
  input logic                   walkReq,
  input logic                   transFault,
  input logic [TLB_ENTRIES-1:0] matchVec
);
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respHit, permAbort, walkReq, transFault}));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || permAbort || walkReq || transFault));

  p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  p_flush_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invalidateAll) && lookupValid) |=> !(respHit || permAbort));
endmodule

bind tlb_match_unit tlb_match_checker u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .invalidateAll(invalidateAll),
  .respValid(respValid), .respHit(respHit), .permAbort(permAbort),
  .walkReq(walkReq), .transFault(transFault), .matchVec(matchVec)
);

// File: tb/test_tlb_match_unit.sv
`timescale 1ns/1ps
module test_tlb_match_unit;
  localparam logic [3:0] O_HIT = 4'b1000, O_ABT = 4'b0100, O_WLK = 4'b0010, O_FLT = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, wrNs = 0, wrGlobal = 0, invalidateAll = 0, lookupValid = 0;
  logic [19:0] wrVpn = '0, wrPfn = '0;
  logic [1:0]  wrSize = '0, wrAp = '0;
  logic [7:0]  wrAsid = '0, lookupAsid = '0;
  logic [3:0]  wrDomain = '0;
  logic [4:0]  wrAttr = '0;
  logic [31:0] lookupVa = '0;
  logic        lookupNs = 0, lookupWrite = 0, lookupPriv = 0;
  logic        walkDisLow = 0, walkDisHigh = 0;
  logic [2:0]  regionSplit = '0;
  logic [31:0] domainCtl = 32'hFFFF_FFFF;
  logic        respValid, respHit, permAbort, walkReq, transFault;
  logic [31:0] respPa;
  logic [4:0]  respAttr;
  int errors = 0, checks = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  tlb_match_unit i_tlb_match_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [19:0] vpn, input logic [1:0] sz, input logic ns,
                            input logic glob, input logic [7:0] asid, input logic [19:0] pfn,
                            input logic [1:0] ap, input logic [3:0] dom, input logic [4:0] attr);
    wrVpn = vpn; wrSize = sz; wrNs = ns; wrGlobal = glob; wrAsid = asid;
    wrPfn = pfn; wrAp = ap; wrDomain = dom; wrAttr = attr; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic flush();
    invalidateAll = 1'b1;
    @(negedge clk);
    invalidateAll = 1'b0;
  endtask

  // Drives on a falling edge; returns at the next falling edge, when the result is due.
  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic ns,
                      input logic wr, input logic priv);
    lookupVa = va; lookupAsid = asid; lookupNs = ns; lookupWrite = wr; lookupPriv = priv;
    lookupValid = 1'b1;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  function automatic logic [3:0] outcome();
    return {respHit, permAbort, walkReq, transFault};
  endfunction

  function automatic logic expOk(input logic [1:0] mode, input logic [1:0] ap,
                                 input logic priv, input logic wr);
    if (mode == 2'b11) return 1'b1;
    if (mode != 2'b01) return 1'b0;
    case (ap)
      2'd0: return 1'b0;
      2'd1: return priv;
      2'd2: return priv || !wr;
      default: return 1'b1;
    endcase
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 respValid idle", {31'b0, respValid}, 32'd0);
    look(32'h1234_5000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R1 empty lookup walks", {28'b0, outcome()}, {28'b0, O_WLK});
    @(negedge clk);
    check("R8 single-cycle response", {31'b0, respValid}, 32'd0);

    // R2 / R7 page-size sweep
    for (int s = 0; s < 4; s++) begin
      automatic int sh = 12 + 4 * s;
      automatic logic [31:0] base = 32'h4000_0000;
      automatic logic [31:0] pmask = (32'h1 << sh) - 1;
      automatic logic [31:0] va = base | (32'h00AB_CDEF & pmask);
      automatic logic [31:0] paBase = 32'h9876_5000;
      flush();
      writeEntry(base[31:12], s[1:0], 1'b0, 1'b1, 8'd0, paBase[31:12], 2'd3, 4'd0, 5'(s + 3));
      look(va, 8'd7, 1'b0, 1'b1, 1'b0);
      check($sformatf("R2 size %0d hit", s), {28'b0, outcome()}, {28'b0, O_HIT});
      check($sformatf("R7 size %0d pa", s), respPa, (paBase & ~pmask) | (va & pmask));
      check($sformatf("R7 size %0d attr", s), {27'b0, respAttr}, 32'(s + 3));
      look(base + (32'h1 << sh), 8'd7, 1'b0, 1'b1, 1'b0);
      check($sformatf("R2 size %0d next page miss", s), {28'b0, outcome()}, {28'b0, O_WLK});
      look(base - 32'h1000, 8'd7, 1'b0, 1'b1, 1'b0);
      check($sformatf("R2 size %0d prev page miss", s), {28'b0, outcome()}, {28'b0, O_WLK});
    end

    // R3 secure-state tag
    flush();
    writeEntry(20'h00010, 2'd0, 1'b0, 1'b1, 8'd0, 20'hAAAAA, 2'd3, 4'd0, 5'd1);
    look(32'h0001_0010, 8'd0, 1'b1, 1'b0, 1'b1);
    check("R3 ns mismatch misses", {28'b0, outcome()}, {28'b0, O_WLK});
    writeEntry(20'h00010, 2'd0, 1'b1, 1'b1, 8'd0, 20'hBBBBB, 2'd3, 4'd0, 5'd2);
    look(32'h0001_0010, 8'd0, 1'b1, 1'b0, 1'b1);
    check("R3 nonsecure copy", respPa, 32'hBBBB_B010);
    look(32'h0001_0010, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R3 secure copy", respPa, 32'hAAAA_A010);

    // R4 identifier or global
    flush();
    writeEntry(20'h00020, 2'd0, 1'b0, 1'b0, 8'd5, 20'h00C00, 2'd3, 4'd0, 5'd0);
    writeEntry(20'h00030, 2'd0, 1'b0, 1'b1, 8'd9, 20'h00D00, 2'd3, 4'd0, 5'd0);
    for (int a = 4; a < 7; a++) begin
      look(32'h0002_0000, 8'(a), 1'b0, 1'b0, 1'b1);
      check($sformatf("R4 asid %0d", a), {28'b0, outcome()}, {28'b0, (a == 5) ? O_HIT : O_WLK});
      look(32'h0003_0000, 8'(a), 1'b0, 1'b0, 1'b1);
      check($sformatf("R4 global asid %0d", a), {28'b0, outcome()}, {28'b0, O_HIT});
    end

    // R5 miss steering over every split value
    flush();
    for (int n = 0; n < 8; n++) begin
      regionSplit = 3'(n);
      walkDisLow = 1'b1; walkDisHigh = 1'b0;
      if (n == 0) begin
        look(32'hFFFF_F000, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R5 split 0 all lower", {28'b0, outcome()}, {28'b0, O_FLT});
      end else begin
        look(32'h1 << (32 - n), 8'd0, 1'b0, 1'b0, 1'b1);
        check($sformatf("R5 split %0d upper walks", n), {28'b0, outcome()}, {28'b0, O_WLK});
        look((32'h1 << (32 - n)) - 32'h1000, 8'd0, 1'b0, 1'b0, 1'b1);
        check($sformatf("R5 split %0d lower faults", n), {28'b0, outcome()}, {28'b0, O_FLT});
        walkDisLow = 1'b0; walkDisHigh = 1'b1;
        look(32'hFFFF_F000, 8'd0, 1'b0, 1'b0, 1'b1);
        check($sformatf("R5 split %0d upper faults", n), {28'b0, outcome()}, {28'b0, O_FLT});
      end
    end
    walkDisLow = 1'b0; walkDisHigh = 1'b0; regionSplit = '0;

    // R6 permission table sweep on domain 6
    for (int m = 0; m < 4; m++) begin
      for (int ap = 0; ap < 4; ap++) begin
        flush();
        domainCtl = 32'hFFFF_FFFF;
        domainCtl[13:12] = 2'(m);
        writeEntry(20'h00050, 2'd0, 1'b0, 1'b1, 8'd0, 20'h00E00, 2'(ap), 4'd6, 5'd4);
        for (int k = 0; k < 4; k++) begin
          automatic logic pr = k[0], wr = k[1];
          look(32'h0005_0123, 8'd0, 1'b0, wr, pr);
          check($sformatf("R6 mode %0d ap %0d priv %0d wr %0d", m, ap, pr, wr),
                {28'b0, outcome()}, {28'b0, expOk(2'(m), 2'(ap), pr, wr) ? O_HIT : O_ABT});
        end
      end
    end
    domainCtl = 32'hFFFF_FFFF;

    // R9 round-robin replacement
    flush();
    for (int i = 0; i < 17; i++)
      writeEntry((i < 16) ? 20'(32'h100 + i) : 20'h00200, 2'd0, 1'b0, 1'b1, 8'd0,
                 20'(32'h300 + i), 2'd3, 4'd0, 5'd0);
    look(32'h0010_0000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R9 first entry replaced", {28'b0, outcome()}, {28'b0, O_WLK});
    look(32'h0010_1000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R9 second entry kept", respPa, 32'h0030_1000);
    look(32'h0020_0000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R9 new entry in slot 0", respPa, 32'h0031_0000);

    // R10 invalidate-all, also against a same-cycle write
    wrVpn = 20'h00400; wrSize = 2'd0; wrGlobal = 1'b1; wrNs = 1'b0; wrAp = 2'd3;
    wrEn = 1'b1; invalidateAll = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; invalidateAll = 1'b0;
    look(32'h0010_1000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R10 old entry gone", {28'b0, outcome()}, {28'b0, O_WLK});
    look(32'h0040_0000, 8'd0, 1'b0, 1'b0, 1'b1);
    check("R10 write dropped by flush", {28'b0, outcome()}, {28'b0, O_WLK});

    done = 1;
    finishRun();
  end
endmodule